// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns software-issued inter-processor interrupt requests into per-CPU pending state. A CPU writes a 32-bit trigger word that names a software interrupt ID and a set of target CPUs. For every target, the block records which source CPUs have asked for that ID. It keeps one source bitmap for each (target CPU, ID) pair. An ID is pending on a target for as long as that bitmap holds any bit.

Each target CPU acknowledges an ID through its own request lane. The block picks the lowest-numbered source still recorded, removes it, and returns the ID together with that source number one cycle later. A separate byte-wide port lets software set or clear chosen source bits in one bitmap directly.

Top module: `sgi_dispatch`

## Requirements
- R1: While reset is high and in the first cycle after it, every `pend` bit and every `ack_valid` bit is 0, and all source bitmaps are empty.
- R2: A trigger write with filter bits [25:24] = 0 targets the CPUs whose bits are set in the list field [23:16]. List bits at or above NUM_CPU are ignored. For each target, the writer's bit is set in the bitmap of the ID given by bits [3:0]. All other data bits have no effect.
- R3: Filter value 1 targets every implemented CPU except the writer.
- R4: Filter value 2 targets only the writer.
- R5: Filter value 3 changes no bitmap and no `pend` bit.
- R6: When `ack_req[t]` is high with ID `ack_id[t]`, `ack_valid[t]` is high in the next cycle. If that bitmap is non-empty, `ack_value[t]` then holds the ID in bits [3:0], zeros in [9:4], and the lowest set source number in [12:10], and that source bit is removed. When `ack_req[t]` is low, `ack_valid[t]` is low in the next cycle.
- R7: `pend[t*NUM_SGI+id]` stays 1 while the bitmap for (t, id) holds any bit and drops to 0 once it is empty. An acknowledge of an empty bitmap returns 0x3FF and changes nothing.
- R8: A byte-port write with `byte_set` = 0 removes the source bits given by `byte_data` from the bitmap for (`byte_cpu`, `byte_id`). Pending drops when that bitmap becomes empty.
- R9: A byte-port write with `byte_set` = 1 adds the source bits given by `byte_data` to that bitmap, which makes the ID pending. `byte_data` bits at or above NUM_CPU are ignored.
- R10: When a set (trigger or byte set) and a clear (acknowledge or byte clear) hit the same bitmap bit in one cycle, the bit ends up set.
- R11: A write or acknowledge in cycle n shows on `pend` from cycle n+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Trigger word write strobe |
| trig_data | input | 32 | Trigger word: ID [3:0], list [23:16], filter [25:24] |
| trig_cpu | input | CPU_W | CPU number of the trigger writer |
| byte_we | input | 1 | Byte-port write strobe |
| byte_set | input | 1 | 1 = add source bits, 0 = remove source bits |
| byte_cpu | input | CPU_W | Target CPU whose bitmap is written |
| byte_id | input | ID_W | Software interrupt ID of the bitmap |
| byte_data | input | 8 | Source CPU bit mask |
| ack_req | input | NUM_CPU | Per-target acknowledge request |
| ack_id | input | NUM_CPU*ID_W | Per-target acknowledged ID, lane t at [t*ID_W +: ID_W] |
| pend | output | NUM_CPU*NUM_SGI | Pending flag, bit t*NUM_SGI+id |
| ack_valid | output | NUM_CPU | Per-target acknowledge result strobe |
| ack_value | output | NUM_CPU*13 | Per-target result, lane t at [t*13 +: 13] |

## Verification
The properties assume that `trig_cpu` and `byte_cpu` always name an implemented CPU and that NUM_CPU is at most 8, so that a source number fits the 3-bit result field. They also assume that no input changes except through the clocked strobes. The stimulus runs with four CPUs, so every 2-bit CPU code it drives is valid. All inputs are driven half a cycle away from the active edge. The trigger words carry junk in the unused bit fields and list bits above the implemented CPUs, so the masking rules are exercised without leaving the assumed input space.

// File: rtl/sgi_pkg.sv
`timescale 1ns/1ps
package sgi_pkg;
  // trigger word field positions
  localparam int TRIG_LIST_LSB = 16;
  localparam int TRIG_FLT_LSB  = 24;
  // acknowledge result layout
  localparam int ACK_SRC_LSB = 10;
  localparam int ACK_W       = 13;
  localparam logic [ACK_W-1:0] ACK_NONE = 13'h3FF;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_NONE   = 2'd3
  } tgt_filter_e;
endpackage

// File: rtl/sgi_trig_decode.sv
`timescale 1ns/1ps
module sgi_trig_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SGI = 16,
  localparam int ID_W  = $clog2(NUM_SGI),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               we,
  input  logic [31:0]        data,
  input  logic [CPU_W-1:0]   cpu,
  output logic [ID_W-1:0]    id,
  output logic [NUM_CPU-1:0] tmask
);
  logic [NUM_CPU-1:0] self_oh;
  tgt_filter_e        flt;
  logic [31:0]        unused_data;

  assign unused_data = data;
  assign id  = data[ID_W-1:0];
  assign flt = tgt_filter_e'(data[TRIG_FLT_LSB +: 2]);

  always_comb begin
    self_oh = '0;
    self_oh[cpu] = 1'b1;
  end

  always_comb begin
    case (flt)
      FLT_LIST:   tmask = data[TRIG_LIST_LSB +: NUM_CPU];
      FLT_OTHERS: tmask = ~self_oh;
      FLT_SELF:   tmask = self_oh;
      default:    tmask = '0;
    endcase
    if (!we) tmask = '0;
  end
endmodule

// File: rtl/sgi_src_pick.sv
`timescale 1ns/1ps
module sgi_src_pick #(
  parameter int NUM_CPU = 4,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [NUM_CPU-1:0] row,
  output logic               found,
  output logic [CPU_W-1:0]   src,
  output logic [NUM_CPU-1:0] onehot
);
  // lowest set bit wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    src   = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (row[i]) begin
        found = 1'b1;
        src   = CPU_W'(i);
      end
    end
    onehot = '0;
    if (found) onehot[src] = 1'b1;
  end
endmodule

// File: rtl/sgi_bitmap_store.sv
`timescale 1ns/1ps
module sgi_bitmap_store #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SGI = 16,
  localparam int ROWS = NUM_CPU * NUM_SGI,
  localparam int BITS = ROWS * NUM_CPU
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] set_bits,
  input  logic [BITS-1:0] clr_bits,
  output logic [BITS-1:0] bm,
  output logic [ROWS-1:0] pend
);
  logic [BITS-1:0] bm_nxt;
  logic [ROWS-1:0] pend_nxt;

  // set overrides clear on the same bit
  assign bm_nxt = (bm & ~clr_bits) | set_bits;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign pend_nxt[r] = |bm_nxt[r*NUM_CPU +: NUM_CPU];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bm   <= '0;
      pend <= '0;
    end else begin
      bm   <= bm_nxt;
      pend <= pend_nxt;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
`timescale 1ns/1ps
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SGI = 16,
  localparam int ID_W  = $clog2(NUM_SGI),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       trig_we,
  input  logic [31:0]                trig_data,
  input  logic [CPU_W-1:0]           trig_cpu,
  input  logic                       byte_we,
  input  logic                       byte_set,
  input  logic [CPU_W-1:0]           byte_cpu,
  input  logic [ID_W-1:0]            byte_id,
  input  logic [7:0]                 byte_data,
  input  logic [NUM_CPU-1:0]         ack_req,
  input  logic [NUM_CPU*ID_W-1:0]    ack_id,
  output logic [NUM_CPU*NUM_SGI-1:0] pend,
  output logic [NUM_CPU-1:0]         ack_valid,
  output logic [NUM_CPU*ACK_W-1:0]   ack_value
);
  localparam int ROWS = NUM_CPU * NUM_SGI;
  localparam int BITS = ROWS * NUM_CPU;

  logic [ID_W-1:0]    trig_id;
  logic [NUM_CPU-1:0] trig_tmask;
  logic [NUM_CPU-1:0] writer_oh;
  logic [NUM_CPU-1:0] byte_src;
  logic [7:0]         unused_byte;
  logic               byte_add;
  logic               byte_del;

  logic [BITS-1:0]    set_bits;
  logic [BITS-1:0]    clr_bits;
  logic [BITS-1:0]    bm_flat;
  logic [NUM_CPU-1:0] bm_row   [ROWS];

  logic [ID_W-1:0]    ack_id_a [NUM_CPU];
  logic [NUM_CPU-1:0] ack_row  [NUM_CPU];
  logic               pick_found [NUM_CPU];
  logic [CPU_W-1:0]   pick_src [NUM_CPU];
  logic [NUM_CPU-1:0] pick_oh  [NUM_CPU];

  sgi_trig_decode #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_dec (
    .we    (trig_we),
    .data  (trig_data),
    .cpu   (trig_cpu),
    .id    (trig_id),
    .tmask (trig_tmask)
  );

  always_comb begin
    writer_oh = '0;
    writer_oh[trig_cpu] = 1'b1;
  end

  assign unused_byte = byte_data;
  assign byte_src = byte_data[NUM_CPU-1:0];
  assign byte_add = byte_we && byte_set;
  assign byte_del = byte_we && !byte_set;

  sgi_bitmap_store #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_store (
    .clk      (clk),
    .rst      (rst),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .bm       (bm_flat),
    .pend     (pend)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_rows
    assign bm_row[r] = bm_flat[r*NUM_CPU +: NUM_CPU];
  end

  // per-target acknowledge lane
  for (genvar t = 0; t < NUM_CPU; t++) begin : g_ack
    assign ack_id_a[t] = ack_id[t*ID_W +: ID_W];
    assign ack_row[t]  = bm_row[t*NUM_SGI + int'(ack_id_a[t])];

    sgi_src_pick #(.NUM_CPU(NUM_CPU)) u_pick (
      .row    (ack_row[t]),
      .found  (pick_found[t]),
      .src    (pick_src[t]),
      .onehot (pick_oh[t])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ack_valid[t]                 <= 1'b0;
        ack_value[t*ACK_W +: ACK_W]  <= '0;
      end else begin
        ack_valid[t] <= ack_req[t];
        if (ack_req[t]) begin
          if (pick_found[t])
            ack_value[t*ACK_W +: ACK_W] <= (ACK_W'(pick_src[t]) << ACK_SRC_LSB)
                                         | ACK_W'(ack_id_a[t]);
          else
            ack_value[t*ACK_W +: ACK_W] <= ACK_NONE;
        end
      end
    end
  end

  // set / clear masks for every (target, id) row
  for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
    for (genvar i = 0; i < NUM_SGI; i++) begin : g_id
      localparam int R = t * NUM_SGI + i;
      logic hit_byte;
      logic hit_ack;
      assign hit_byte = (byte_cpu == CPU_W'(t)) && (byte_id == ID_W'(i));
      assign hit_ack  = ack_req[t] && (ack_id_a[t] == ID_W'(i));

      assign set_bits[R*NUM_CPU +: NUM_CPU] =
          ((trig_tmask[t] && trig_id == ID_W'(i)) ? writer_oh : {NUM_CPU{1'b0}})
        | ((byte_add && hit_byte) ? byte_src : {NUM_CPU{1'b0}});

      assign clr_bits[R*NUM_CPU +: NUM_CPU] =
          ((byte_del && hit_byte) ? byte_src : {NUM_CPU{1'b0}})
        | (hit_ack ? pick_oh[t] : {NUM_CPU{1'b0}});
    end
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
`timescale 1ns/1ps
module sgi_dispatch_chk
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SGI = 16,
  localparam int ID_W  = $clog2(NUM_SGI),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       trig_we,
  input logic [31:0]                trig_data,
  input logic [CPU_W-1:0]           trig_cpu,
  input logic                       byte_we,
  input logic                       byte_set,
  input logic [NUM_CPU-1:0]         ack_req,
  input logic [NUM_CPU*NUM_SGI-1:0] pend,
  input logic [NUM_CPU-1:0]         ack_valid,
  input logic [NUM_CPU*ACK_W-1:0]   ack_value
);
  int          self_idx;
  logic [1:0]  flt;
  logic [31:0] unused_td;

  assign unused_td = trig_data;
  assign flt = trig_data[TRIG_FLT_LSB +: 2];
  always_comb self_idx = int'(trig_cpu) * NUM_SGI + int'(trig_data[ID_W-1:0]);

  // R4: a self-targeted trigger leaves its own ID pending next cycle
  a_r4_self_pending: assert property (@(posedge clk) disable iff (rst)
    (trig_we && flt == 2'd2) |=> pend[$past(self_idx)]);

  // R5: the invalid filter is quiet when nothing else acts
  a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
    (trig_we && flt == 2'd3 && !byte_we && ack_req == '0) |=> $stable(pend));

  // R6: every request gets exactly one result strobe a cycle later
  a_r6_ack_strobe: assert property (@(posedge clk) disable iff (rst)
    (ack_req == ack_req) |=> (ack_valid == $past(ack_req)));

  // R7: pending never drops without an acknowledge or byte clear
  a_r7_no_drop: assert property (@(posedge clk) disable iff (rst)
    (ack_req == '0 && !(byte_we && !byte_set)) |=> ((pend & $past(pend)) == $past(pend)));

  // R9: pending never rises without a trigger or byte set
  a_r9_no_rise: assert property (@(posedge clk) disable iff (rst)
    (!trig_we && !(byte_we && byte_set)) |=> ((pend & ~$past(pend)) == '0));

  for (genvar t = 0; t < NUM_CPU; t++) begin : g_lane
    // R6: a real result names an implemented source and has a clean middle field
    a_r6_result_shape: assert property (@(posedge clk) disable iff (rst)
      (ack_valid[t] && ack_value[t*ACK_W +: ACK_W] != ACK_NONE) |->
        (int'(ack_value[t*ACK_W + ACK_SRC_LSB +: 3]) < NUM_CPU &&
         ack_value[t*ACK_W + ID_W +: (ACK_SRC_LSB - ID_W)] == '0));
  end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_we   (trig_we),
  .trig_data (trig_data),
  .trig_cpu  (trig_cpu),
  .byte_we   (byte_we),
  .byte_set  (byte_set),
  .ack_req   (ack_req),
  .pend      (pend),
  .ack_valid (ack_valid),
  .ack_value (ack_value)
);

// File: tb/sgi_dispatch_test.sv
`timescale 1ns/1ps
module sgi_dispatch_test;
  localparam int NC = 4;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_we = 1'b0;
  logic [31:0] trig_data = '0;
  logic [1:0]  trig_cpu = '0;
  logic        byte_we = 1'b0;
  logic        byte_set = 1'b0;
  logic [1:0]  byte_cpu = '0;
  logic [3:0]  byte_id = '0;
  logic [7:0]  byte_data = '0;
  logic [3:0]  ack_req = '0;
  logic [15:0] ack_id = '0;
  logic [63:0] pend;
  logic [3:0]  ack_valid;
  logic [51:0] ack_value;

  always #2 clk = ~clk;

  sgi_dispatch #(.NUM_CPU(NC), .NUM_SGI(NS)) uut (
    .clk(clk), .rst(rst), .trig_we(trig_we), .trig_data(trig_data), .trig_cpu(trig_cpu),
    .byte_we(byte_we), .byte_set(byte_set), .byte_cpu(byte_cpu), .byte_id(byte_id),
    .byte_data(byte_data), .ack_req(ack_req), .ack_id(ack_id),
    .pend(pend), .ack_valid(ack_valid), .ack_value(ack_value)
  );

  int checks = 0;
  int fails  = 0;
  logic [3:0] mb [NC][NS];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_pend();
    logic [63:0] v;
    for (int t = 0; t < NC; t++)
      for (int i = 0; i < NS; i++)
        v[t*NS+i] = |mb[t][i];
    return v;
  endfunction

  function automatic logic [3:0] tmask(int f, logic [7:0] l, int w);
    case (f)
      0: return l[3:0];
      1: return 4'hF & ~(4'h1 << w);
      2: return 4'h1 << w;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [12:0] exp_ack(int t, int id);
    for (int s = 0; s < NC; s++)
      if (mb[t][id][s]) return {3'(s), 6'b0, 4'(id)};
    return 13'h3FF;
  endfunction

  task automatic idle();
    trig_we = 0; byte_we = 0; byte_set = 0; ack_req = '0; ack_id = '0;
  endtask

  task automatic apply(string tag, bit tw, int tcpu, int tf, logic [7:0] tl, int tid,
                       bit bwe, bit bset, int bcpu, int bid, logic [7:0] bd,
                       logic [3:0] areq, logic [15:0] aid);
    logic [12:0] ea [NC];
    logic [3:0]  m;
    trig_we = tw; trig_cpu = 2'(tcpu);
    trig_data = {6'h2A, 2'(tf), tl, 12'h5C3, 4'(tid)};
    byte_we = bwe; byte_set = bset; byte_cpu = 2'(bcpu); byte_id = 4'(bid); byte_data = bd;
    ack_req = areq; ack_id = aid;
    for (int t = 0; t < NC; t++) ea[t] = exp_ack(t, int'(aid[t*4 +: 4]));
    @(posedge clk);
    @(negedge clk);
    idle();
    chk(ack_valid == areq, tag, 64'(ack_valid), 64'(areq));
    for (int t = 0; t < NC; t++)
      if (areq[t]) chk(ack_value[t*13 +: 13] == ea[t], tag, 64'(ack_value[t*13 +: 13]), 64'(ea[t]));
    // clears first, then sets (set wins)
    for (int t = 0; t < NC; t++)
      if (areq[t] && ea[t] != 13'h3FF) mb[t][int'(aid[t*4 +: 4])][ea[t][11:10]] = 1'b0;
    if (bwe && !bset) mb[bcpu][bid] = mb[bcpu][bid] & ~bd[3:0];
    if (tw) begin
      m = tmask(tf, tl, tcpu);
      for (int t = 0; t < NC; t++) if (m[t]) mb[t][tid][tcpu] = 1'b1;
    end
    if (bwe && bset) mb[bcpu][bid] = mb[bcpu][bid] | bd[3:0];
    chk(pend == exp_pend(), tag, pend, exp_pend());
  endtask

  task automatic trig(string tag, int w, int f, logic [7:0] l, int id);
    apply(tag, 1, w, f, l, id, 0, 0, 0, 0, 8'h00, 4'h0, 16'h0);
  endtask

  task automatic ack1(string tag, int t, int id);
    apply(tag, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 8'h00, 4'h1 << t, 16'(id) << (4*t));
  endtask

  task automatic bytep(string tag, bit set, int c, int id, logic [7:0] d);
    apply(tag, 0, 0, 0, 8'h00, 0, 1, set, c, id, d, 4'h0, 16'h0);
  endtask

  task automatic drain(string tag);
    for (int t = 0; t < NC; t++)
      for (int i = 0; i < NS; i++)
        while (mb[t][i] != 4'h0) ack1(tag, t, i);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] lists [4];
    string tg;
    lists[0] = 8'hFF; lists[1] = 8'h00; lists[2] = 8'h09; lists[3] = 8'h36;
    for (int t = 0; t < NC; t++) for (int i = 0; i < NS; i++) mb[t][i] = 4'h0;

    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pend == '0, "R1 pend", pend, 0);
    chk(ack_valid == '0, "R1 ack_valid", 64'(ack_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pend == '0, "R1 pend after release", pend, 0);
    ack1("R7 empty after reset", 0, 3);

    // R2..R5 sweep over writer, filter and list
    for (int w = 0; w < NC; w++)
      for (int f = 0; f < 4; f++)
        for (int li = 0; li < 4; li++) begin
          tg = (f == 0) ? "R2" : (f == 1) ? "R3" : (f == 2) ? "R4" : "R5";
          trig(tg, w, f, lists[li], (w*5 + f*3 + li) % NS);
          drain("R6 drain");
        end

    // R6: several sources on one ID drain lowest first
    for (int w = 0; w < NC; w++) trig("R3 multi", w, 1, 8'h00, 7);
    trig("R2 multi", 3, 0, 8'h0F, 7);
    drain("R6 lowest first");
    ack1("R7 empty", 2, 7);

    // R7: pending held until last source removed
    trig("R2", 0, 0, 8'h04, 12);
    trig("R2", 3, 0, 8'h04, 12);
    ack1("R7 partial", 2, 12);
    ack1("R7 last", 2, 12);
    ack1("R7 spurious", 2, 12);

    // R8, R9: byte port
    bytep("R9 set masked", 1, 2, 9, 8'hF5);
    bytep("R8 clear partial", 0, 2, 9, 8'h01);
    bytep("R8 clear last", 0, 2, 9, 8'hF4);
    bytep("R9 set", 1, 0, 15, 8'h08);
    ack1("R9 ack", 0, 15);
    for (int c = 0; c < NC; c++) begin
      bytep("R9 sweep", 1, c, c + 4, 8'(c*3 + 9));
      bytep("R8 sweep", 0, c, c + 4, 8'(1 << c));
      drain("R8 drain");
    end

    // R10: set beats clear
    bytep("R9", 1, 1, 5, 8'h02);
    apply("R10 trig vs ack", 1, 1, 2, 8'h00, 5, 0, 0, 0, 0, 8'h00, 4'b0010, 16'h0050);
    drain("R10 drain");
    bytep("R9", 1, 3, 0, 8'h04);
    apply("R10 trig vs byte clear", 1, 2, 0, 8'h08, 0, 1, 0, 3, 0, 8'h04, 4'h0, 16'h0);
    drain("R10 drain");
    trig("R3", 0, 1, 8'h00, 2);
    apply("R6 parallel acks", 1, 3, 1, 8'h00, 2, 0, 0, 0, 0, 8'h00, 4'b1110, 16'h2220);
    drain("R6 drain");

    // R11: update lands after the edge, not before
    trig_we = 1; trig_cpu = 2'd0; trig_data = {6'h00, 2'd2, 8'h00, 12'h000, 4'd1};
    #1;
    chk(pend[1] == 1'b0, "R11 before edge", 64'(pend[1]), 0);
    @(posedge clk);
    @(negedge clk);
    idle();
    chk(pend[1] == 1'b1, "R11 after edge", 64'(pend[1]), 1);
    mb[0][1][0] = 1'b1;
    drain("R11 drain");

    summary();
    $finish;
  end
endmodule